// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is the datapath of a small stack machine. It runs instructions that name no register operands. Each instruction arrives as a 3-bit opcode and a memory address, with a start strobe. The unit accepts the strobe while it is ready. A load moves one word from a synchronous data memory onto an internal operand stack. A store moves the top word back to memory and removes it from the stack. The four arithmetic operations each remove the two topmost words and leave one result on the stack.

All values are 16-bit two's-complement integers. For subtraction and division, the top of the stack is the left operand and the word below it is the right operand. So if F, E and D are loaded in that order, a multiply followed by a subtract leaves D*E-F. The stack is a file of 16 registers with an occupancy counter. Three sticky flags report errors: loading onto a full stack, running an instruction that needs more entries than the stack holds, and dividing by zero. The unit raises a one-cycle completion pulse at the end of every instruction.

The memory port is a synchronous RAM port. Read data appears one clock after a read strobe, and a write takes effect at the clock edge where the write strobe is high.

Top module: `zs_unit`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0, all three error flags are 0 and the stack is empty.
- R2: Opcode 0 (load) reads memory at addr_i and places the word on top of the stack.
- R3: Opcode 1 (store) writes the top word to memory at addr_i and removes it, so words leave in last-in-first-out order.
- R4: Opcode 2 adds, opcode 3 subtracts and opcode 4 multiplies. Each removes the two topmost words and pushes one result. Subtraction is top minus next, and multiplication keeps the low 16 bits of the product.
- R5: Opcode 5 divides top by next as signed integers, with the quotient truncated toward zero and wrapped to 16 bits.
- R6: A divide whose next word is zero sets the sticky dz_o flag, consumes both words and pushes zero.
- R7: A load onto a stack that already holds 16 words sets the sticky ovf_o flag and leaves the stack unchanged.
- R8: A store on an empty stack, or an arithmetic opcode with fewer than two words, sets the sticky unf_o flag and leaves the stack unchanged.
- R9: A start is accepted only while ready_o is 1. ready_o stays 0 from the cycle after acceptance until done_o. done_o is high for exactly one cycle per instruction, and ready_o returns in the next cycle.
- R10: Opcodes 6 and 7 complete with a done_o pulse and change neither the stack nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction strobe, sampled while ready_o is 1 |
| op_i | input | 3 | Opcode |
| addr_i | input | 8 | Memory address for load and store |
| ready_o | output | 1 | Unit idle and able to accept an instruction |
| done_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after mem_re_o |
| ovf_o | output | 1 | Sticky stack-overflow flag |
| unf_o | output | 1 | Sticky too-few-operands flag |
| dz_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The expression D*E-F is evaluated from three loaded words to confirm that results stay on the stack and that the operand order is top-first. Subtracting a larger next word from a smaller top word gives a negative result, which separates top-minus-next from the reverse order. Division is run with every sign combination, with a result that truncates to zero, and with the most negative value over minus one, which separates truncation toward zero from flooring and tests the wrap to 16 bits. A full sixteen-deep fill followed by a refused load and sixteen stores shows that overflow leaves the contents and their order intact. An undefined opcode and the underflow cases are each followed by a store, so that an untouched stack is visible in memory.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_MUL   = 3'd4,
    OP_DIV   = 3'd5
  } zs_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_CAP,
    S_WR,
    S_EXE,
    S_DIV,
    S_FIN
  } zs_state_e;
endpackage

// File: rtl/zs_stack.sv
module zs_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          fold_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] top_o,
  output logic [DW-1:0] next_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          pair_o
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] cnt_m1, cnt_m2;

  assign cnt_m1 = count_q - CW'(1);
  assign cnt_m2 = count_q - CW'(2);

  // push writes slot count; fold overwrites slot count-2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((push_i && count_q == CW'(i)) || (fold_i && cnt_m2 == CW'(i)))
          ent_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_q <= '0;
    else if (push_i)          count_q <= count_q + CW'(1);
    else if (pop_i || fold_i) count_q <= cnt_m1;
  end

  always_comb begin
    top_o  = '0;
    next_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_m1 == CW'(i)) top_o  = ent_q[i];
      if (cnt_m2 == CW'(i)) next_o = ent_q[i];
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign pair_o  = (count_q >= CW'(2));
endmodule

// File: rtl/zs_alu.sv
module zs_alu
  import zs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] top_i,
  input  logic [DW-1:0] next_i,
  output logic [DW-1:0] res_o
);
  // two's-complement wrap makes low bits sign-agnostic
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = top_i + next_i;
      OP_SUB:  res_o = top_i - next_i;
      OP_MUL:  res_o = top_i * next_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/zs_div.sv
module zs_div #(
  parameter int DW  = 16,
  localparam int NW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  logic          run_q, neg_q;
  logic [NW-1:0] cnt_q;
  logic [DW:0]   rem_q;
  logic [DW-1:0] quo_q, dvs_q;
  logic [DW-1:0] mag_a, mag_b;
  logic [DW:0]   shl, diff;

  assign mag_a = dividend_i[DW-1] ? -dividend_i : dividend_i;
  assign mag_b = divisor_i[DW-1]  ? -divisor_i  : divisor_i;

  assign shl  = {rem_q[DW-1:0], quo_q[DW-1]};
  assign diff = shl - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      neg_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      neg_q <= dividend_i[DW-1] ^ divisor_i[DW-1];
      cnt_q <= NW'(DW);
      rem_q <= '0;
      quo_q <= mag_a;
      dvs_q <= mag_b;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - NW'(1);
        if (!diff[DW]) begin
          rem_q <= diff;
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= shl;
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o = run_q && (cnt_q == '0);
  assign quot_o = neg_q ? -quo_q : quo_q;
endmodule

// File: rtl/zs_unit.sv
module zs_unit
  import zs_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          dz_o
);
  localparam int CW = $clog2(DEPTH + 1);

  zs_state_e     state_q, state_d;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic          ovf_q, unf_q, dz_q;
  logic          set_ovf, set_unf, set_dz;

  logic          stk_push, stk_pop, stk_fold;
  logic [DW-1:0] stk_wdata, stk_top, stk_next;
  logic [CW-1:0] stk_count;
  logic          stk_full, stk_empty, stk_pair;

  logic [DW-1:0] alu_res;
  logic          div_start, div_done;
  logic [DW-1:0] div_quot;

  zs_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .fold_i  (stk_fold),
    .wdata_i (stk_wdata),
    .top_o   (stk_top),
    .next_o  (stk_next),
    .count_o (stk_count),
    .full_o  (stk_full),
    .empty_o (stk_empty),
    .pair_o  (stk_pair)
  );

  zs_alu #(.DW(DW)) u_alu (
    .op_i   (op_q),
    .top_i  (stk_top),
    .next_i (stk_next),
    .res_o  (alu_res)
  );

  zs_div #(.DW(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (stk_top),
    .divisor_i  (stk_next),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // errors are decided at accept time, before any state changes
  always_comb begin
    state_d   = state_q;
    set_ovf   = 1'b0;
    set_unf   = 1'b0;
    set_dz    = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        unique case (op_i)
          OP_LOAD: begin
            if (stk_full) begin set_ovf = 1'b1; state_d = S_FIN; end
            else state_d = S_RD;
          end
          OP_STORE: begin
            if (stk_empty) begin set_unf = 1'b1; state_d = S_FIN; end
            else state_d = S_WR;
          end
          OP_ADD, OP_SUB, OP_MUL: begin
            if (!stk_pair) begin set_unf = 1'b1; state_d = S_FIN; end
            else state_d = S_EXE;
          end
          OP_DIV: begin
            if (!stk_pair) begin
              set_unf = 1'b1;
              state_d = S_FIN;
            end else if (stk_next == '0) begin
              set_dz  = 1'b1;
              state_d = S_EXE;
            end else begin
              div_start = 1'b1;
              state_d   = S_DIV;
            end
          end
          default: state_d = S_FIN;
        endcase
      end
      S_RD:  state_d = S_CAP;
      S_CAP: state_d = S_FIN;
      S_WR:  state_d = S_FIN;
      S_EXE: state_d = S_FIN;
      S_DIV: if (div_done) state_d = S_FIN;
      S_FIN: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        op_q   <= op_i;
        addr_q <= addr_i;
      end
      if (set_ovf) ovf_q <= 1'b1;
      if (set_unf) unf_q <= 1'b1;
      if (set_dz)  dz_q  <= 1'b1;
    end
  end

  // divide-by-zero reaches S_EXE where the alu yields zero for OP_DIV
  assign stk_push  = (state_q == S_CAP);
  assign stk_pop   = (state_q == S_WR);
  assign stk_fold  = (state_q == S_EXE) || (state_q == S_DIV && div_done);
  assign stk_wdata = (state_q == S_CAP) ? mem_rdata_i :
                     (state_q == S_EXE) ? alu_res : div_quot;

  assign ready_o     = (state_q == S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign mem_re_o    = (state_q == S_RD);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = stk_top;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign dz_o        = dz_q;
endmodule

// File: rtl/zs_unit_chk.sv
module zs_unit_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ready_o,
  input logic          done_o,
  input logic          mem_re_o,
  input logic          mem_we_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          dz_o,
  input logic [CW-1:0] count_i
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);
  // R9
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R8
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  // R6
  dz_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |=> dz_o);
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));
  // R2
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  // R3
  store_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !ready_o);
endmodule

bind zs_unit zs_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .mem_re_o (mem_re_o),
  .mem_we_o (mem_we_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o),
  .dz_o     (dz_o),
  .count_i  (stk_count)
);

// File: tb/zs_unit_bench.sv
module zs_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  addr = '0;
  logic        ready, done, mre, mwe, ovf, unf, dz;
  logic [7:0]  maddr;
  logic [15:0] wdata, rdata;

  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = '0;
  logic [15:0] tb_d = '0;
  logic [15:0] mem [256];

  int checks = 0;
  int errors = 0;

  logic [15:0] model [$];
  logic        e_ovf = 1'b0, e_unf = 1'b0, e_dz = 1'b0;
  logic [23:0] exp_q [$];
  string       req_q [$];

  always #5 clk = ~clk;

  zs_unit u_zs_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .ready_o(ready), .done_o(done), .mem_re_o(mre), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .ovf_o(ovf), .unf_o(unf), .dz_o(dz)
  );

  always @(posedge clk) begin
    if (mwe) mem[maddr] <= wdata;
    else if (tb_we) mem[tb_a] <= tb_d;
    if (mre) rdata <= mem[maddr];
  end

  // monitor: compares each memory write with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && mwe) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected write addr=%0d data=%h expected none", maddr, wdata);
      end else begin
        logic [23:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({maddr, wdata} !== e) begin
          errors++;
          $display("FAIL %s store actual addr=%0d data=%h expected addr=%0d data=%h",
                   r, maddr, wdata, e[23:16], e[15:0]);
        end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // driver: updates the reference stack and queues expected stores
  task automatic exec(input logic [2:0] o, input logic [7:0] a, input string r);
    logic [15:0] t, n, res;
    int q;
    @(negedge clk);
    while (!ready) @(negedge clk);
    case (o)
      3'd0: if (model.size() == 16) e_ovf = 1'b1; else model.push_back(mem[a]);
      3'd1: if (model.size() == 0) e_unf = 1'b1;
            else begin exp_q.push_back({a, model.pop_back()}); req_q.push_back(r); end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        if (model.size() < 2) e_unf = 1'b1;
        else begin
          t = model.pop_back();
          n = model.pop_back();
          case (o)
            3'd2: res = t + n;
            3'd3: res = t - n;
            3'd4: res = 16'((32'(t) * 32'(n)));
            default: begin
              if (n == 16'd0) begin e_dz = 1'b1; res = '0; end
              else begin q = int'($signed(t)) / int'($signed(n)); res = q[15:0]; end
            end
          endcase
          model.push_back(res);
        end
      end
      default: ;
    endcase
    start = 1'b1; op = o; addr = a;
    @(negedge clk);
    start = 1'b0;
    chk({r, " R9 busy after accept"}, {31'd0, ready}, 32'd0);
    while (!done) @(negedge clk);
    chk({r, " R7 ovf"}, {31'd0, ovf}, {31'd0, e_ovf});
    chk({r, " R8 unf"}, {31'd0, unf}, {31'd0, e_unf});
    chk({r, " R6 dz"},  {31'd0, dz},  {31'd0, e_dz});
    @(negedge clk);
    chk({r, " R9 done one cycle"}, {30'd0, done, ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    preload(8'd10, 16'd3);   preload(8'd11, 16'd5);   preload(8'd12, 16'd7);
    preload(8'd20, 16'd300); preload(8'd21, 16'd300);
    preload(8'd22, 16'h7FFF); preload(8'd23, 16'd1);
    preload(8'd30, 16'd3);   preload(8'd31, 16'hFFEC);
    preload(8'd32, 16'hFFFE); preload(8'd33, 16'hFFF9);
    preload(8'd34, 16'hFFFE); preload(8'd35, 16'd7);
    preload(8'd36, 16'd0);   preload(8'd37, 16'd5);
    preload(8'd40, 16'd9);   preload(8'd41, 16'h8000); preload(8'd42, 16'hFFFF);
    for (int i = 0; i < 16; i++) preload(8'(50 + i), 16'(i * 11 + 1));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, ready}, 32'd1);
    chk("R1 done",  {31'd0, done}, 32'd0);
    chk("R1 flags", {29'd0, ovf, unf, dz}, 32'd0);
    // R1 empty stack: store underflows (R8)
    exec(3'd1, 8'd200, "R1");
    // R8 binary op with one entry leaves it in place
    exec(3'd0, 8'd40, "R2");
    exec(3'd2, 8'd0, "R8");
    exec(3'd1, 8'd201, "R8");
    // R4 D*E-F
    exec(3'd0, 8'd10, "R2"); exec(3'd0, 8'd11, "R2"); exec(3'd0, 8'd12, "R2");
    exec(3'd4, 8'd0, "R4"); exec(3'd3, 8'd0, "R4");
    exec(3'd1, 8'd100, "R4");
    // R4 product wrap
    exec(3'd0, 8'd20, "R2"); exec(3'd0, 8'd21, "R2");
    exec(3'd4, 8'd0, "R4"); exec(3'd1, 8'd101, "R4");
    // R4 sum wrap
    exec(3'd0, 8'd23, "R2"); exec(3'd0, 8'd22, "R2");
    exec(3'd2, 8'd0, "R4"); exec(3'd1, 8'd102, "R4");
    // R4 top minus next, negative result
    exec(3'd0, 8'd12, "R2"); exec(3'd0, 8'd10, "R2");
    exec(3'd3, 8'd0, "R4"); exec(3'd1, 8'd103, "R4");
    // R5 sign combinations and truncation
    exec(3'd0, 8'd30, "R2"); exec(3'd0, 8'd31, "R2");
    exec(3'd5, 8'd0, "R5"); exec(3'd1, 8'd104, "R5");
    exec(3'd0, 8'd32, "R2"); exec(3'd0, 8'd33, "R2");
    exec(3'd5, 8'd0, "R5"); exec(3'd1, 8'd105, "R5");
    exec(3'd0, 8'd34, "R2"); exec(3'd0, 8'd35, "R2");
    exec(3'd5, 8'd0, "R5"); exec(3'd1, 8'd106, "R5");
    exec(3'd0, 8'd42, "R2"); exec(3'd0, 8'd41, "R2");
    exec(3'd5, 8'd0, "R5"); exec(3'd1, 8'd107, "R5");
    exec(3'd0, 8'd40, "R2"); exec(3'd0, 8'd12, "R2");
    exec(3'd5, 8'd0, "R5"); exec(3'd1, 8'd108, "R5");
    // R10 undefined opcodes
    exec(3'd0, 8'd35, "R2");
    exec(3'd6, 8'd109, "R10"); exec(3'd7, 8'd109, "R10");
    exec(3'd1, 8'd110, "R10");
    // R6 divide by zero
    exec(3'd0, 8'd36, "R2"); exec(3'd0, 8'd37, "R2");
    exec(3'd5, 8'd0, "R6"); exec(3'd1, 8'd111, "R6");
    // R7 full stack then refused load, contents intact
    for (int i = 0; i < 16; i++) exec(3'd0, 8'(50 + i), "R2");
    exec(3'd0, 8'd10, "R7");
    for (int i = 0; i < 16; i++) exec(3'd1, 8'(120 + i), "R7");
    exec(3'd1, 8'd140, "R8");
    repeat (3) @(negedge clk);
    chk("R3 all stores seen", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule